// File: doc/BRIEF.md
# Multi-Mode Mantissa Rounding Unit

This block takes a mantissa that carries two extra low-order bits (guard above round) together with a sticky bit. It rounds the mantissa to its final width under one of four directed rounding modes. The direction of rounding depends on both the mode and the operand's sign. Round-to-nearest breaks ties toward an even result.

The result is registered once. It comes out the cycle after the operands are presented, with the two extra bits removed.

The unit only rounds. It does not renormalise, adjust any exponent, or pack the result. When an increment carries out of the top bit, the mantissa wraps to zero and a separate carry output is raised, and the caller fixes the value up. The increment is built from parameterised word segments, so the carry runs through a wide mantissa one word at a time.

Top module: `mant_round`

## Requirements
- R1: The truncated part of the result is `mant_i[MANT_W+1:2]`. Bit 1 of `mant_i` is the guard bit and bit 0 is the round bit, and both are discarded.
- R2: When guard, round and sticky are all zero, the result is the truncated mantissa. `rounded_up_o` and `inexact_o` are both 0.
- R3: `inexact_o` is 1 exactly when at least one of guard, round or sticky is 1, in every mode.
- R4: In mode 2'b00 (nearest), the mantissa is incremented only when guard is 1 and at least one of round, sticky or the truncated LSB is 1.
- R5: In mode 2'b01 (toward zero), the mantissa is never incremented.
- R6: In mode 2'b10 (toward minus infinity), the mantissa is incremented exactly when the result is inexact and `sign_i` is 1.
- R7: In mode 2'b11 (toward plus infinity), the mantissa is incremented exactly when the result is inexact and `sign_i` is 0.
- R8: `rounded_up_o` is 1 exactly when an increment was applied. `mant_o` then equals the truncated value plus one, with the carry passed across every word boundary.
- R9: `carry_o` is 1 exactly when the increment overflows the `MANT_W`-bit result. In that case `mant_o` is zero and no correction is made.
- R10: Outputs are registered. Each reflects the inputs sampled at the previous rising edge. While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mant_i | input | MANT_W+2 | Mantissa with guard (bit 1) and round (bit 0) |
| sticky_i | input | 1 | OR of all bits below the round bit |
| sign_i | input | 1 | Operand sign, 1 = negative |
| mode_i | input | 2 | Rounding mode: 00 nearest, 01 zero, 10 minus inf, 11 plus inf |
| mant_o | output | MANT_W | Rounded mantissa |
| rounded_up_o | output | 1 | Increment was applied |
| inexact_o | output | 1 | Discarded bits were nonzero |
| carry_o | output | 1 | Increment overflowed the mantissa width |

## Verification
The assertions compare each output with the inputs sampled one edge earlier, so they assume the inputs are known and stable across every edge after reset is released. To let the checker ignore the first edge after reset, it keeps a primed flag. The stimulus drives every input on the falling edge and holds it for a full cycle. It never leaves an input unknown after reset, and it sweeps every mantissa, sticky, sign and mode combination of a 6-bit, two-segment configuration.

// File: rtl/mant_round_pkg.sv
package mant_round_pkg;
  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_ZERO    = 2'b01,
    RM_NEG     = 2'b10,
    RM_POS     = 2'b11
  } rmode_e;
endpackage

// File: rtl/mant_round_decide.sv
module mant_round_decide
  import mant_round_pkg::*;
(
  input  logic       guard_i,
  input  logic       round_i,
  input  logic       sticky_i,
  input  logic       lsb_i,
  input  logic       sign_i,
  input  logic [1:0] mode_i,
  output logic       inc_o,
  output logic       inexact_o
);
  logic   lost;
  rmode_e mode;

  assign lost      = guard_i | round_i | sticky_i;
  assign inexact_o = lost;
  assign mode      = rmode_e'(mode_i);

  always_comb begin
    unique case (mode)
      RM_ZERO: inc_o = 1'b0;
      RM_NEG:  inc_o = lost & sign_i;
      RM_POS:  inc_o = lost & ~sign_i;
      default: inc_o = guard_i & (round_i | sticky_i | lsb_i); // ties to even
    endcase
  end
endmodule

// File: rtl/mant_round_inc.sv
module mant_round_inc #(
  parameter int MANT_W = 64,
  parameter int WORD_W = 32
) (
  input  logic [MANT_W-1:0] val_i,
  input  logic              inc_i,
  output logic [MANT_W-1:0] sum_o,
  output logic              carry_o
);
  localparam int NW    = (MANT_W + WORD_W - 1) / WORD_W;
  localparam int TOT_W = NW * WORD_W;
  localparam int PAD_W = TOT_W - MANT_W;

  logic [TOT_W-1:0] val_pad;
  logic [TOT_W-1:0] sum_pad;
  logic [NW:0]      c;

  generate
    if (PAD_W > 0) begin : g_pad
      assign val_pad = {{PAD_W{1'b0}}, val_i};
    end else begin : g_nopad
      assign val_pad = val_i;
    end
  endgenerate

  assign c[0] = inc_i;

  // Segmented increment: each word adds its carry-in, passes carry on all-ones.
  for (genvar k = 0; k < NW; k++) begin : g_word
    logic [WORD_W-1:0] w;
    assign w = val_pad[k*WORD_W +: WORD_W];
    assign sum_pad[k*WORD_W +: WORD_W] = w + {{(WORD_W-1){1'b0}}, c[k]};
    assign c[k+1] = c[k] & (&w);
  end

  assign sum_o = sum_pad[MANT_W-1:0];

  generate
    if (PAD_W > 0) begin : g_cy_pad
      logic unused_hi;
      assign carry_o   = sum_pad[MANT_W];
      assign unused_hi = ^{sum_pad[TOT_W-1:MANT_W], c[NW]};
    end else begin : g_cy_full
      assign carry_o = c[NW];
    end
  endgenerate
endmodule

// File: rtl/mant_round.sv
module mant_round #(
  parameter int MANT_W = 64,
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MANT_W+1:0] mant_i,
  input  logic              sticky_i,
  input  logic              sign_i,
  input  logic [1:0]        mode_i,
  output logic [MANT_W-1:0] mant_o,
  output logic              rounded_up_o,
  output logic              inexact_o,
  output logic              carry_o
);
  logic [MANT_W-1:0] trunc;
  logic [MANT_W-1:0] sum;
  logic              inc, inx, cy;

  assign trunc = mant_i[MANT_W+1:2];

  mant_round_decide u_decide (
    .guard_i  (mant_i[1]),
    .round_i  (mant_i[0]),
    .sticky_i (sticky_i),
    .lsb_i    (mant_i[2]),
    .sign_i   (sign_i),
    .mode_i   (mode_i),
    .inc_o    (inc),
    .inexact_o(inx)
  );

  mant_round_inc #(.MANT_W(MANT_W), .WORD_W(WORD_W)) u_inc (
    .val_i  (trunc),
    .inc_i  (inc),
    .sum_o  (sum),
    .carry_o(cy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mant_o       <= '0;
      rounded_up_o <= 1'b0;
      inexact_o    <= 1'b0;
      carry_o      <= 1'b0;
    end else begin
      mant_o       <= sum;
      rounded_up_o <= inc;
      inexact_o    <= inx;
      carry_o      <= cy;
    end
  end
endmodule

// File: rtl/mant_round_chk.sv
module mant_round_chk #(
  parameter int MANT_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [MANT_W+1:0] mant_i,
  input logic              sticky_i,
  input logic              sign_i,
  input logic [1:0]        mode_i,
  input logic [MANT_W-1:0] mant_o,
  input logic              rounded_up_o,
  input logic              inexact_o,
  input logic              carry_o
);
  logic primed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed <= 1'b0;
    else         primed <= 1'b1;
  end

  AST_EXACT_NO_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(mant_i[1:0] == 2'b00 && !sticky_i) |-> !rounded_up_o && !inexact_o); // R2
  AST_INEXACT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed |-> inexact_o == $past(mant_i[1] | mant_i[0] | sticky_i)); // R3
  AST_NEAR_NO_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(mode_i == 2'b00 && !mant_i[1]) |-> !rounded_up_o); // R4
  AST_RTZ_TRUNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(mode_i == 2'b01) |-> !rounded_up_o); // R5
  AST_NEG_POSITIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(mode_i == 2'b10 && !sign_i) |-> !rounded_up_o); // R6
  AST_POS_NEGATIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(mode_i == 2'b11 && sign_i) |-> !rounded_up_o); // R7
  AST_UP_INEXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rounded_up_o |-> inexact_o); // R8
  AST_CARRY_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |-> rounded_up_o && mant_o == '0); // R9
endmodule

bind mant_round mant_round_chk #(.MANT_W(MANT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mant_i(mant_i), .sticky_i(sticky_i),
  .sign_i(sign_i), .mode_i(mode_i), .mant_o(mant_o),
  .rounded_up_o(rounded_up_o), .inexact_o(inexact_o), .carry_o(carry_o)
);

// File: tb/mant_round_bench.sv
module mant_round_bench;
  localparam int MW = 6;
  localparam int WW = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [MW+1:0] mant_i = '0;
  logic          sticky_i = 1'b0;
  logic          sign_i = 1'b0;
  logic [1:0]    mode_i = 2'b00;
  logic [MW-1:0] mant_o;
  logic          rounded_up_o, inexact_o, carry_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  mant_round #(.MANT_W(MW), .WORD_W(WW)) u_mant_round (
    .clk_i(clk_i), .rst_ni(rst_ni), .mant_i(mant_i), .sticky_i(sticky_i),
    .sign_i(sign_i), .mode_i(mode_i), .mant_o(mant_o),
    .rounded_up_o(rounded_up_o), .inexact_o(inexact_o), .carry_o(carry_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d (mant_i=%0d st=%0b sg=%0b md=%0d)",
               tag, act, exp, mant_i, sticky_i, sign_i, mode_i);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk(mant_o == 0, "R10", mant_o, 0);
    chk({rounded_up_o, inexact_o, carry_o} == 3'b000, "R10",
        {rounded_up_o, inexact_o, carry_o}, 0);
    rst_ni = 1'b1;
    for (int v = 0; v < (1 << (MW + 2)); v++) begin
      for (int s = 0; s < 2; s++) begin
        for (int sg = 0; sg < 2; sg++) begin
          for (int m = 0; m < 4; m++) begin
            int tr, g, r, lost, up, sum, ecy, emant;
            string tag;
            mant_i = v[MW+1:0]; sticky_i = s[0]; sign_i = sg[0]; mode_i = m[1:0];
            tr = v >> 2; g = (v >> 1) & 1; r = v & 1;
            lost = (g | r | s) != 0 ? 1 : 0;
            case (m)
              0: begin up = (g == 1 && (r == 1 || s == 1 || (tr & 1) == 1)) ? 1 : 0; tag = "R4"; end
              1: begin up = 0; tag = "R5"; end
              2: begin up = (lost == 1 && sg == 1) ? 1 : 0; tag = "R6"; end
              default: begin up = (lost == 1 && sg == 0) ? 1 : 0; tag = "R7"; end
            endcase
            sum = tr + up;
            ecy = sum >> MW;
            emant = sum & ((1 << MW) - 1);
            @(posedge clk_i);
            @(negedge clk_i);
            chk(int'(rounded_up_o) == up, tag, rounded_up_o, up);
            chk(int'(inexact_o) == lost, "R3", inexact_o, lost);
            if (lost == 0)
              chk(!rounded_up_o && int'(mant_o) == tr, "R2", mant_o, tr);
            if (up == 0)
              chk(int'(mant_o) == tr, "R1", mant_o, tr);
            else if ((tr & ((1 << WW) - 1)) == (1 << WW) - 1)
              chk(int'(mant_o) == emant, "R8", mant_o, emant); // crosses word
            else
              chk(int'(mant_o) == emant, "R8", mant_o, emant);
            chk(int'(carry_o) == ecy, "R9", carry_o, ecy);
          end
        end
      end
    end
    // reset while outputs nonzero (last vector: all ones, plus-inf, rounds up)
    mant_i = '1; sticky_i = 1'b1; sign_i = 1'b0; mode_i = 2'b11;
    @(posedge clk_i); @(negedge clk_i);
    chk(carry_o == 1'b1, "R9", carry_o, 1);
    rst_ni = 1'b0;
    #1;
    chk({rounded_up_o, inexact_o, carry_o} == 3'b000 && mant_o == 0, "R10",
        {rounded_up_o, inexact_o, carry_o}, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule